// File: doc/BRIEF.md
# Calibrated Code-to-Temperature Converter

This block turns a raw 12-bit reading from an on-die temperature sensor into a signed temperature in millidegrees Celsius. It also runs the mapping the other way, from a temperature to a sensor code, so that alarm thresholds can be written in sensor units. Both directions use a straight line through two calibration points. The two factory trim codes give the sensor readings at the two fixed temperatures, -41 °C for the low trim and 126 °C for the high trim.

A request is a single-cycle `start` with a direction bit, an operand and the trim pair. The block first checks that the trim pair is usable. It then forms a wide signed product and divides it by a signed divisor using an iterative divider. Finally it adds the offset and saturates the answer to the legal range. `busy` covers the whole computation. A one-cycle `done` marks the moment `result` and `error` become valid, and both stay unchanged until the next request is accepted.

Top module: `thermcal_conv`

## Requirements
- R1: With `inverse`=0 and a valid trim pair, `result` equals trunc(167000·(code − lo)/(hi − lo)) − 41000. Here code is `value_in[11:0]`, lo is `trim_lo`, hi is `trim_hi`, and the division truncates toward zero.
- R2: In forward mode the value from R1 is saturated into the range −41000 to 126000 inclusive.
- R3: With `inverse`=1 and a valid trim pair, `result` equals trunc((T + 41000)·(hi − lo)/167000) + lo. Here T is `value_in` read as a signed 32-bit number.
- R4: In inverse mode the value from R3 is saturated into the range 0 to 4095 inclusive.
- R5: A trim pair is invalid when either value is 0, either value is 0xFFF, or the two values are equal. An accepted start with an invalid pair raises `done` and `error` on the next clock edge with `result`=0, and `busy` never rises.
- R6: In forward mode, bits 31:12 of `value_in` have no effect on `result`.
- R7: After the edge that accepts a valid start, `busy` is 1 until `done` is asserted. `done` is a one-cycle pulse on the 49th clock edge after the accepting edge, and `busy` is 0 from that edge on.
- R8: A `start` while `busy` is 1 is ignored. The running request finishes with its own operands and its own timing.
- R9: During and right after reset, `busy`, `done`, `error` and `result` are all 0.
- R10: `result` and `error` keep their values from the end of one request until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted only while idle |
| inverse | input | 1 | 0: code to temperature, 1: temperature to code |
| value_in | input | 32 | Sensor code in bits 11:0 (forward) or signed millidegrees (inverse) |
| trim_lo | input | 12 | Calibration code at −41 °C |
| trim_hi | input | 12 | Calibration code at 126 °C |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result and error valid |
| error | output | 1 | Last request had an invalid trim pair |
| result | output | 32 | Signed millidegrees (forward) or code 0..4095 (inverse) |

## Verification
The assertions assume that the divider is never loaded with a zero divisor, which holds only because the trim check rejects equal codes before any division starts. They also assume that the operand of an inverse request, being 32 bits, always keeps the product inside the 48-bit datapath. The stimulus draws trim codes from 1 to 4094 and forces them to differ, except in the directed invalid cases. Inverse temperatures are drawn from a window that runs past both calibration endpoints, so saturation is exercised from the valid side as well as with the extreme values.

// File: rtl/thermcal_pkg.sv
`timescale 1ns/1ps
package thermcal_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} cv_state_t;
  localparam int LOW_POINT_MC  = -41000;
  localparam int HIGH_POINT_MC = 126000;
endpackage

// File: rtl/thermcal_trim_chk.sv
`timescale 1ns/1ps
module thermcal_trim_chk #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  output logic              ok
);
  localparam logic [CODE_W-1:0] ALL_ONES = '1;
  localparam logic [CODE_W-1:0] ALL_ZERO = '0;

  always_comb begin
    ok = (lo != ALL_ZERO) && (hi != ALL_ZERO) &&
         (lo != ALL_ONES) && (hi != ALL_ONES) && (lo != hi);
  end
endmodule

// File: rtl/thermcal_prep.sv
`timescale 1ns/1ps
module thermcal_prep #(
  parameter int CODE_W = 12,
  parameter int VAL_W  = 32,
  parameter int PROD_W = 48,
  parameter int T_LO   = -41000,
  parameter int T_HI   = 126000
) (
  input  logic              inverse,
  input  logic [VAL_W-1:0]  value,
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  output logic [PROD_W-1:0] num_mag,
  output logic [PROD_W-1:0] den_mag,
  output logic              q_neg
);
  localparam logic signed [PROD_W-1:0] SPAN = PROD_W'(T_HI - T_LO);
  localparam logic signed [PROD_W-1:0] BASE = PROD_W'(T_LO);

  logic signed [PROD_W-1:0] lo_s, hi_s, trim_d, code_s, val_s, prod, den;
  logic num_neg, den_neg;

  always_comb begin
    lo_s   = signed'({{(PROD_W-CODE_W){1'b0}}, lo});
    hi_s   = signed'({{(PROD_W-CODE_W){1'b0}}, hi});
    trim_d = hi_s - lo_s;
    code_s = signed'({{(PROD_W-CODE_W){1'b0}}, value[CODE_W-1:0]});
    val_s  = signed'({{(PROD_W-VAL_W){value[VAL_W-1]}}, value});
    if (inverse) begin
      prod = (val_s - BASE) * trim_d;
      den  = SPAN;
    end else begin
      prod = (code_s - lo_s) * SPAN;
      den  = trim_d;
    end
    num_neg = prod[PROD_W-1];
    den_neg = den[PROD_W-1];
    num_mag = num_neg ? PROD_W'(-prod) : PROD_W'(prod);
    den_mag = den_neg ? PROD_W'(-den) : PROD_W'(den);
    q_neg   = num_neg ^ den_neg;
  end
endmodule

// File: rtl/thermcal_divu.sv
`timescale 1ns/1ps
module thermcal_divu #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem, acc, den_q;
  logic [CW-1:0] cnt;
  logic          act;
  logic [W:0]    trial;
  logic          ge;
  logic [W-1:0]  sub;

  always_comb begin
    trial = {rem, acc[W-1]};
    ge    = trial >= {1'b0, den_q};
    sub   = trial[W-1:0] - den_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      acc   <= '0;
      den_q <= '0;
      cnt   <= '0;
      act   <= 1'b0;
      fin   <= 1'b0;
    end else if (load) begin
      rem   <= '0;
      acc   <= num;
      den_q <= den;
      cnt   <= '0;
      act   <= 1'b1;
      fin   <= 1'b0;
    end else if (act) begin
      rem <= ge ? sub : trial[W-1:0];
      acc <= {acc[W-2:0], ge};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(W-1)) begin
        act <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quo = acc;

  // R1: the trim check must keep a zero divisor away from the divider
  assert_den_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    load |-> (den != '0));
  // R1: restoring invariant, partial remainder below divisor
  assert_rem_below_R1: assert property (@(posedge clk) disable iff (rst)
    act |-> (rem < den_q));
  // R7: completion is a single pulse
  assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/thermcal_post.sv
`timescale 1ns/1ps
module thermcal_post #(
  parameter int CODE_W = 12,
  parameter int VAL_W  = 32,
  parameter int PROD_W = 48,
  parameter int T_LO   = -41000,
  parameter int T_HI   = 126000
) (
  input  logic              inverse,
  input  logic              q_neg,
  input  logic [PROD_W-1:0] q_mag,
  input  logic [CODE_W-1:0] lo,
  output logic [VAL_W-1:0]  res
);
  localparam int EW = PROD_W + 2;
  localparam logic signed [EW-1:0] FWD_MIN = EW'(T_LO);
  localparam logic signed [EW-1:0] FWD_MAX = EW'(T_HI);
  localparam logic signed [EW-1:0] INV_MIN = '0;
  localparam logic signed [EW-1:0] INV_MAX = signed'({{(EW-CODE_W){1'b0}}, {CODE_W{1'b1}}});

  logic signed [EW-1:0] q_s, off, sum, lim_lo, lim_hi, sat;

  always_comb begin
    q_s    = signed'({2'b00, q_mag});
    if (q_neg) q_s = -q_s;
    off    = inverse ? signed'({{(EW-CODE_W){1'b0}}, lo}) : FWD_MIN;
    lim_lo = inverse ? INV_MIN : FWD_MIN;
    lim_hi = inverse ? INV_MAX : FWD_MAX;
    sum    = q_s + off;
    if (sum < lim_lo)      sat = lim_lo;
    else if (sum > lim_hi) sat = lim_hi;
    else                   sat = sum;
    res = VAL_W'(sat);
  end
endmodule

// File: rtl/thermcal_conv.sv
`timescale 1ns/1ps
module thermcal_conv
  import thermcal_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int VAL_W  = 32,
  parameter int PROD_W = 48,
  parameter int T_LO   = LOW_POINT_MC,
  parameter int T_HI   = HIGH_POINT_MC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              inverse,
  input  logic [VAL_W-1:0]  value_in,
  input  logic [CODE_W-1:0] trim_lo,
  input  logic [CODE_W-1:0] trim_hi,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [VAL_W-1:0]  result
);
  localparam logic [VAL_W-1:0] CODE_MAX = VAL_W'((1 << CODE_W) - 1);

  cv_state_t         state;
  logic              trim_ok;
  logic [PROD_W-1:0] num_mag, den_mag, quo;
  logic              q_neg, neg_q, mode_q, div_fin;
  logic [CODE_W-1:0] lo_q;
  logic [VAL_W-1:0]  post_res;
  logic              accept;

  assign accept = start && (state == ST_IDLE);

  thermcal_trim_chk #(.CODE_W(CODE_W)) u_trim (
    .lo(trim_lo), .hi(trim_hi), .ok(trim_ok)
  );

  thermcal_prep #(.CODE_W(CODE_W), .VAL_W(VAL_W), .PROD_W(PROD_W),
                  .T_LO(T_LO), .T_HI(T_HI)) u_prep (
    .inverse(inverse), .value(value_in), .lo(trim_lo), .hi(trim_hi),
    .num_mag(num_mag), .den_mag(den_mag), .q_neg(q_neg)
  );

  thermcal_divu #(.W(PROD_W)) u_div (
    .clk(clk), .rst(rst), .load(accept && trim_ok),
    .num(num_mag), .den(den_mag), .quo(quo), .fin(div_fin)
  );

  thermcal_post #(.CODE_W(CODE_W), .VAL_W(VAL_W), .PROD_W(PROD_W),
                  .T_LO(T_LO), .T_HI(T_HI)) u_post (
    .inverse(mode_q), .q_neg(neg_q), .q_mag(quo), .lo(lo_q), .res(post_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      result <= '0;
      mode_q <= 1'b0;
      neg_q  <= 1'b0;
      lo_q   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (!trim_ok) begin
              done   <= 1'b1;
              error  <= 1'b1;
              result <= '0;
            end else begin
              state  <= ST_RUN;
              busy   <= 1'b1;
              error  <= 1'b0;
              mode_q <= inverse;
              neg_q  <= q_neg;
              lo_q   <= trim_lo;
            end
          end
        end
        default: begin
          if (div_fin) begin
            state  <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= post_res;
          end
        end
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_fwd_range_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !error && !mode_q) |->
      ($signed(result) >= $signed(VAL_W'(T_LO)) && $signed(result) <= $signed(VAL_W'(T_HI))));
  assert_inv_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !error && mode_q) |-> (result <= CODE_MAX));
  assert_bad_trim_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !trim_ok) |=> (done && error && !busy));
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(lo_q) && $stable(neg_q)));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(error)));
endmodule

// File: tb/test_thermcal_conv.sv
`timescale 1ns/1ps
module test_thermcal_conv;
  localparam int  LAT  = 50;
  localparam longint FLO = -41000;
  localparam longint FHI = 126000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        inverse = 1'b0;
  logic [31:0] value_in = '0;
  logic [11:0] trim_lo = '0;
  logic [11:0] trim_hi = '0;
  logic        busy, done, error;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  thermcal_conv i_thermcal_conv (
    .clk(clk), .rst(rst), .start(start), .inverse(inverse),
    .value_in(value_in), .trim_lo(trim_lo), .trim_hi(trim_hi),
    .busy(busy), .done(done), .error(error), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_fwd(input longint code, input longint b, input longint c);
    longint r;
    r = ((FHI - FLO) * (code - b)) / (c - b) + FLO;
    if (r < FLO) r = FLO;
    if (r > FHI) r = FHI;
    return r;
  endfunction

  function automatic longint ref_inv(input longint t, input longint b, input longint c);
    longint r;
    r = ((t - FLO) * (c - b)) / (FHI - FLO) + b;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic run_op(input bit m, input logic [31:0] v, input logic [11:0] b, input logic [11:0] c);
    longint exp;
    string  req;
    bit     valid;
    int     n;
    valid = (b != 0) && (c != 0) && (b != 12'hFFF) && (c != 12'hFFF) && (b != c);
    if (m) begin
      exp = ref_inv(longint'($signed(v)), b, c);
      req = (exp == 0 || exp == 4095) ? "R4" : "R3";
    end else begin
      exp = ref_fwd(v[11:0], b, c);
      req = (exp == FLO || exp == FHI) ? "R2" : "R1";
    end
    @(negedge clk);
    start = 1'b1; inverse = m; value_in = v; trim_lo = b; trim_hi = c;
    @(negedge clk);
    start = 1'b0;
    if (!valid) begin
      chk(done && error && !busy, "R5", {done, error, busy}, 3'b110);
      chk(result == 0, "R5", result, 0);
      return;
    end
    chk(busy == 1'b1, "R7", busy, 1);
    n = 1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n == LAT, "R7", n, LAT);
    chk(!error, req, error, 0);
    chk(longint'($signed(result)) == exp, req, longint'($signed(result)), exp);
    @(negedge clk);
    chk(!done && !busy, "R7", {done, busy}, 0);
    chk(longint'($signed(result)) == exp, "R10", longint'($signed(result)), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd97531));
    repeat (3) @(negedge clk);
    chk({busy, done, error} == 3'b000 && result == 0, "R9", {busy, done, error}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, error} == 3'b000 && result == 0, "R9", result, 0);

    // directed forward corners (R1, R2)
    run_op(1'b0, 32'd1500, 12'd1500, 12'd3000);
    run_op(1'b0, 32'd3000, 12'd1500, 12'd3000);
    run_op(1'b0, 32'd0,    12'd1500, 12'd3000);
    run_op(1'b0, 32'd4095, 12'd1500, 12'd3000);
    run_op(1'b0, 32'd2001, 12'd1500, 12'd3000);
    run_op(1'b0, 32'd1499, 12'd1500, 12'd3000);
    run_op(1'b0, 32'd2500, 12'd3200, 12'd900);
    // R6: upper operand bits ignored in forward mode
    run_op(1'b0, 32'hABCDE7D1, 12'd1500, 12'd3000);
    // directed inverse corners (R3, R4)
    run_op(1'b1, -32'sd41000, 12'd1500, 12'd3000);
    run_op(1'b1, 32'sd126000, 12'd1500, 12'd3000);
    run_op(1'b1, 32'h7FFFFFFF, 12'd1500, 12'd3000);
    run_op(1'b1, 32'h80000000, 12'd1500, 12'd3000);
    run_op(1'b1, 32'sd25333, 12'd3200, 12'd900);
    run_op(1'b1, -32'sd40999, 12'd2, 12'd4094);
    // R5: invalid trim pairs
    run_op(1'b0, 32'd100, 12'd0, 12'd3000);
    run_op(1'b1, 32'd100, 12'd1200, 12'hFFF);
    run_op(1'b0, 32'd100, 12'd777, 12'd777);
    // R10: error flag and zero result are held while idle
    repeat (3) @(negedge clk);
    chk(error && result == 0, "R10", error, 1);

    // R8: a start during a run is ignored
    begin
      longint exp;
      int n;
      exp = ref_fwd(2222, 1000, 3500);
      @(negedge clk);
      start = 1'b1; inverse = 1'b0; value_in = 32'd2222; trim_lo = 12'd1000; trim_hi = 12'd3500;
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(negedge clk);
      start = 1'b1; inverse = 1'b1; value_in = 32'd5; trim_lo = 12'd0; trim_hi = 12'd0;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done, "R8", {busy, done}, 2'b10);
      n = 11;
      while (!done && n < 400) begin
        @(negedge clk);
        n++;
      end
      chk(n == LAT, "R8", n, LAT);
      chk(!error && longint'($signed(result)) == exp, "R8", longint'($signed(result)), exp);
      @(negedge clk);
      chk(!done, "R8", done, 0);
    end

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic [11:0] b, c;
      bit m;
      logic [31:0] v;
      b = 12'($urandom_range(1, 4094));
      c = 12'($urandom_range(1, 4094));
      if (b == c) c = (b == 12'd4094) ? 12'd1 : b + 12'd1;
      m = 1'($urandom_range(0, 1));
      if (m) v = 32'($signed(32'($urandom_range(0, 220000))) - 32'sd60000);
      else   v = {20'($urandom()), 12'($urandom())};
      run_op(m, v, b, c);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule